// File: doc/BRIEF.md
# Packet Address Byte Compressor

This block shortens the address header of request packets on a serial packet link. It has two halves, one for each end of the link. The transmit half compares each request address with the last address it sent. It then issues a header holding a per-byte presence mask and the packet kind. After the header it streams out only the address bytes that changed, one byte per cycle. The receive half takes that header and the byte stream. It rebuilds the full address by filling every absent byte position from the last address it reconstructed.

Read responses carry no address at all. Neither half updates its address history for them. A disable input forces the transmit half to send every byte. An error indication on the link clears the history on both halves, so the next addressed request goes out in full. Line coding and payload words are handled elsewhere. A burst of up to 16 data words follows a single header, so the header cost is paid once per burst.

Top module: `addr_byte_compressor`

## Requirements
- R1: With the disable input low and a valid history, mask bit n (n = 0..3) is 1 exactly when address bits 8n+7..8n differ from the same bits of the last address sent.
- R2: The present bytes leave on the byte port one per cycle, lowest byte index first. They start the cycle after the header. There is one byte per mask bit set, and a byte never shares a cycle with a header.
- R3: A read response (kind code 2) gets mask 0 and sends no bytes. The history on both halves is left unchanged by it.
- R4: While the disable input is high at acceptance, an addressed request gets mask 4'hF.
- R5: After reset, or after a cycle with the link error input high, the next addressed request gets mask 4'hF.
- R6: The receive half presents the rebuilt address one cycle after the last byte of a packet. When an addressed packet carries mask 0, it presents the address one cycle after the header. Absent bytes come from the last rebuilt address.
- R7: For a read response, the receive half presents kind 2 with address 0 one cycle after the header.
- R8: The transmit ready output is low exactly while bytes of the current packet remain to be sent. A request is accepted on a clock edge where valid and ready are both high.
- R9: The header appears for one cycle, the cycle after acceptance, carrying the mask and the request kind (0 write, 1 read, 2 read response).
- R10: After reset, ready is high and the header valid, byte valid and address valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_err | input | 1 | Link error seen; clears address history on both halves |
| tx_req_valid | input | 1 | Request present |
| tx_req_kind | input | 2 | 0 write, 1 read, 2 read response |
| tx_req_addr | input | 32 | Request address |
| tx_opt_dis | input | 1 | Send all address bytes |
| tx_req_ready | output | 1 | Transmit half can accept a request |
| tx_hdr_valid | output | 1 | Header present |
| tx_hdr_mask | output | 4 | Byte presence mask |
| tx_hdr_kind | output | 2 | Packet kind |
| tx_byte_valid | output | 1 | Address byte present |
| tx_byte | output | 8 | Address byte |
| rx_hdr_valid | input | 1 | Received header present |
| rx_hdr_mask | input | 4 | Received presence mask |
| rx_hdr_kind | input | 2 | Received packet kind |
| rx_byte_valid | input | 1 | Received address byte present |
| rx_byte | input | 8 | Received address byte |
| rx_addr_valid | output | 1 | Rebuilt address present |
| rx_addr | output | 32 | Rebuilt address (0 for a read response) |
| rx_addr_kind | output | 2 | Kind of the rebuilt packet |

## Verification
The assertions check several things on every cycle. A response header never carries a mask, and the disable input and a cold history force a full mask. Headers and bytes never overlap, and a pending byte count holds ready low. On the receive side, a response yields address 0 and leaves the history untouched. Only the bench's loopback scenarios can show that byte values arrive in ascending order and that the mask tracks exactly the changed bytes. They also show that the rebuilt address equals the original across long random address sequences with interleaved error pulses.

// File: rtl/addr_cmp_pkg.sv
package addr_cmp_pkg;
  localparam logic [1:0] KIND_WR  = 2'd0;
  localparam logic [1:0] KIND_RD  = 2'd1;
  localparam logic [1:0] KIND_RSP = 2'd2;

  function automatic logic kind_has_addr(input logic [1:0] k);
    return k != KIND_RSP;
  endfunction
endpackage

// File: rtl/addr_cmp_mask.sv
module addr_cmp_mask #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = ADDR_W / BYTE_W
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] prev,
  input  logic              prev_ok,
  input  logic              force_all,
  input  logic              has_addr,
  output logic [NB-1:0]     mask
);
  for (genvar n = 0; n < NB; n++) begin : g_byte
    logic differs;
    assign differs = cur[n*BYTE_W +: BYTE_W] != prev[n*BYTE_W +: BYTE_W];
    assign mask[n] = has_addr & (force_all | ~prev_ok | differs);
  end
endmodule

// File: rtl/addr_cmp_tx.sv
module addr_cmp_tx
  import addr_cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = ADDR_W / BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_err,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              opt_dis,
  output logic              req_ready,
  output logic              hdr_valid,
  output logic [NB-1:0]     hdr_mask,
  output logic [1:0]        hdr_kind,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  logic [ADDR_W-1:0] hist;
  logic              hist_ok;
  logic [ADDR_W-1:0] shadow;
  logic [NB-1:0]     pend;
  logic [NB-1:0]     new_mask;
  logic [NB-1:0]     low_bit;
  logic [IDX_W-1:0]  low_idx;
  logic              accept;
  logic              has_addr;

  assign accept    = req_valid & req_ready;
  assign has_addr  = kind_has_addr(req_kind);
  assign req_ready = (pend == '0);
  assign low_bit   = pend & (~pend + 1'b1);

  always_comb begin
    low_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = IDX_W'(i);
    end
  end

  addr_cmp_mask #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mask (
    .cur       (req_addr),
    .prev      (hist),
    .prev_ok   (hist_ok & ~link_err),
    .force_all (opt_dis),
    .has_addr  (has_addr),
    .mask      (new_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist       <= '0;
      hist_ok    <= 1'b0;
      shadow     <= '0;
      pend       <= '0;
      hdr_valid  <= 1'b0;
      hdr_mask   <= '0;
      hdr_kind   <= KIND_WR;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      hdr_valid  <= 1'b0;
      byte_valid <= 1'b0;
      if (pend != '0) begin
        byte_valid <= 1'b1;
        byte_data  <= shadow[low_idx*BYTE_W +: BYTE_W];
        pend       <= pend & ~low_bit;
      end
      if (link_err) hist_ok <= 1'b0;
      if (accept) begin
        hdr_valid <= 1'b1;
        hdr_mask  <= new_mask;
        hdr_kind  <= req_kind;
        shadow    <= req_addr;
        pend      <= new_mask;
        if (has_addr) begin
          hist    <= req_addr;
          hist_ok <= 1'b1;
        end
      end
    end
  end

  p_resp_nomask_r3: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_kind == KIND_RSP |-> hdr_mask == '0);
  p_dis_full_r4: assert property (@(posedge clk) disable iff (rst)
    accept && opt_dis && has_addr |=> hdr_valid && hdr_mask == '1);
  p_cold_full_r5: assert property (@(posedge clk) disable iff (rst)
    accept && has_addr && !hist_ok |=> hdr_mask == '1);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid && byte_valid));
  p_busy_after_hdr_r8: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_mask != '0 |-> !req_ready);
endmodule

// File: rtl/addr_cmp_rx.sv
module addr_cmp_rx
  import addr_cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = ADDR_W / BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_err,
  input  logic              hdr_valid,
  input  logic [NB-1:0]     hdr_mask,
  input  logic [1:0]        hdr_kind,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        addr_kind
);
  logic [ADDR_W-1:0] hist;
  logic              hist_ok;
  logic [ADDR_W-1:0] work;
  logic [ADDR_W-1:0] merged;
  logic [NB-1:0]     need;
  logic [NB-1:0]     low_bit;
  logic [NB-1:0]     need_next;
  logic [IDX_W-1:0]  low_idx;
  logic [1:0]        cur_kind;

  assign low_bit   = need & (~need + 1'b1);
  assign need_next = need & ~low_bit;

  always_comb begin
    low_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (need[i]) low_idx = IDX_W'(i);
    end
    merged = work;
    merged[low_idx*BYTE_W +: BYTE_W] = byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist       <= '0;
      hist_ok    <= 1'b0;
      work       <= '0;
      need       <= '0;
      cur_kind   <= KIND_WR;
      addr_valid <= 1'b0;
      addr       <= '0;
      addr_kind  <= KIND_WR;
    end else begin
      addr_valid <= 1'b0;
      if (link_err) hist_ok <= 1'b0;
      if (hdr_valid) begin
        cur_kind <= hdr_kind;
        if (!kind_has_addr(hdr_kind)) begin
          addr_valid <= 1'b1;
          addr       <= '0;
          addr_kind  <= hdr_kind;
          need       <= '0;
        end else if (hdr_mask == '0) begin
          addr_valid <= 1'b1;
          addr       <= hist;
          addr_kind  <= hdr_kind;
          need       <= '0;
        end else begin
          need <= hdr_mask;
          work <= hist;
        end
      end else if (byte_valid && need != '0) begin
        work <= merged;
        need <= need_next;
        if (need_next == '0) begin
          addr_valid <= 1'b1;
          addr       <= merged;
          addr_kind  <= cur_kind;
          hist       <= merged;
          hist_ok    <= 1'b1;
        end
      end
    end
  end

  p_cold_full_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && kind_has_addr(hdr_kind) && !hist_ok |-> hdr_mask == '1);
  p_resp_zero_r7: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_kind == KIND_RSP |=> addr_valid && addr == '0 && addr_kind == KIND_RSP);
  p_hist_keep_r3: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_kind == KIND_RSP |=> $stable(hist));
  p_done_empty_r6: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> need == '0);
endmodule

// File: rtl/addr_byte_compressor.sv
module addr_byte_compressor #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = ADDR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_err,
  input  logic              tx_req_valid,
  input  logic [1:0]        tx_req_kind,
  input  logic [ADDR_W-1:0] tx_req_addr,
  input  logic              tx_opt_dis,
  output logic              tx_req_ready,
  output logic              tx_hdr_valid,
  output logic [NB-1:0]     tx_hdr_mask,
  output logic [1:0]        tx_hdr_kind,
  output logic              tx_byte_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_hdr_valid,
  input  logic [NB-1:0]     rx_hdr_mask,
  input  logic [1:0]        rx_hdr_kind,
  input  logic              rx_byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_addr_valid,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [1:0]        rx_addr_kind
);
  addr_cmp_tx #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .link_err   (link_err),
    .req_valid  (tx_req_valid),
    .req_kind   (tx_req_kind),
    .req_addr   (tx_req_addr),
    .opt_dis    (tx_opt_dis),
    .req_ready  (tx_req_ready),
    .hdr_valid  (tx_hdr_valid),
    .hdr_mask   (tx_hdr_mask),
    .hdr_kind   (tx_hdr_kind),
    .byte_valid (tx_byte_valid),
    .byte_data  (tx_byte)
  );

  addr_cmp_rx #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .link_err   (link_err),
    .hdr_valid  (rx_hdr_valid),
    .hdr_mask   (rx_hdr_mask),
    .hdr_kind   (rx_hdr_kind),
    .byte_valid (rx_byte_valid),
    .byte_data  (rx_byte),
    .addr_valid (rx_addr_valid),
    .addr       (rx_addr),
    .addr_kind  (rx_addr_kind)
  );
endmodule

// File: tb/addr_byte_compressor_tb.sv
module addr_byte_compressor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_err = 1'b0;
  logic        req_v = 1'b0;
  logic [1:0]  req_k = 2'd0;
  logic [31:0] req_a = '0;
  logic        opt = 1'b0;
  logic        tx_req_ready, tx_hdr_valid, tx_byte_valid;
  logic [3:0]  tx_hdr_mask;
  logic [1:0]  tx_hdr_kind, rx_addr_kind;
  logic [7:0]  tx_byte;
  logic        rx_addr_valid;
  logic [31:0] rx_addr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  addr_byte_compressor u_dut (
    .clk(clk), .rst(rst), .link_err(link_err),
    .tx_req_valid(req_v), .tx_req_kind(req_k), .tx_req_addr(req_a), .tx_opt_dis(opt),
    .tx_req_ready(tx_req_ready), .tx_hdr_valid(tx_hdr_valid), .tx_hdr_mask(tx_hdr_mask),
    .tx_hdr_kind(tx_hdr_kind), .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte),
    .rx_hdr_valid(tx_hdr_valid), .rx_hdr_mask(tx_hdr_mask), .rx_hdr_kind(tx_hdr_kind),
    .rx_byte_valid(tx_byte_valid), .rx_byte(tx_byte),
    .rx_addr_valid(rx_addr_valid), .rx_addr(rx_addr), .rx_addr_kind(rx_addr_kind)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: byte queue plus expectation registers
  byte unsigned q[$];
  bit          e_hv, e_bv, e_blast, e_av, h_ok, rdy;
  logic [3:0]  e_mask;
  logic [1:0]  e_kind, e_ak;
  logic [31:0] e_addr, e_aa, h;
  logic [7:0]  e_b;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      e_hv = 0; e_bv = 0; e_av = 0; e_blast = 0; h_ok = 0;
    end else begin
      rdy  = (q.size() == 0);
      e_av = 0;
      if (e_hv && e_mask == 4'h0) begin
        e_av = 1; e_aa = (e_kind == 2'd2) ? 32'h0 : e_addr; e_ak = e_kind;
      end
      if (e_bv && e_blast) begin
        e_av = 1; e_aa = e_addr; e_ak = e_kind;
      end
      e_bv = 0;
      if (q.size() > 0) begin
        e_b = q.pop_front(); e_bv = 1; e_blast = (q.size() == 0);
      end
      e_hv = 0;
      if (req_v && rdy) begin
        e_hv = 1; e_kind = req_k; e_addr = req_a; e_mask = 4'h0;
        if (req_k != 2'd2) begin
          for (int n = 0; n < 4; n++) begin
            if (opt || !h_ok || link_err || h[8*n +: 8] != req_a[8*n +: 8]) begin
              e_mask[n] = 1'b1;
              q.push_back(req_a[8*n +: 8]);
            end
          end
          h = req_a; h_ok = 1;
        end else if (link_err) h_ok = 0;
      end else if (link_err) h_ok = 0;
    end
  end

  bit started = 0;
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(tx_req_ready == (q.size() == 0), "R8 ready", 32'(tx_req_ready), 32'(q.size() == 0));
      chk(tx_hdr_valid == e_hv, "R9 hdr_valid", 32'(tx_hdr_valid), 32'(e_hv));
      if (e_hv) begin
        chk(tx_hdr_mask == e_mask, "R1 mask", 32'(tx_hdr_mask), 32'(e_mask));
        chk(tx_hdr_kind == e_kind, "R9 kind", 32'(tx_hdr_kind), 32'(e_kind));
      end
      chk(tx_byte_valid == e_bv, "R2 byte_valid", 32'(tx_byte_valid), 32'(e_bv));
      if (e_bv) chk(tx_byte == e_b, "R2 byte", 32'(tx_byte), 32'(e_b));
      chk(rx_addr_valid == e_av, "R6 addr_valid", 32'(rx_addr_valid), 32'(e_av));
      if (e_av) begin
        chk(rx_addr == e_aa, (e_ak == 2'd2) ? "R7 addr" : "R6 addr", rx_addr, e_aa);
        chk(rx_addr_kind == e_ak, "R6 kind", 32'(rx_addr_kind), 32'(e_ak));
      end
    end
  end

  task automatic send(input logic [1:0] k, input logic [31:0] a, input logic dis);
    @(negedge clk);
    while (!tx_req_ready) @(negedge clk);
    req_v = 1'b1; req_k = k; req_a = a; opt = dis;
    @(negedge clk);
    req_v = 1'b0; opt = 1'b0;
  endtask

  task automatic mask_is(input logic [3:0] exp, input string tag);
    chk(tx_hdr_valid && tx_hdr_mask == exp, tag, 32'(tx_hdr_mask), 32'(exp));
  endtask

  task automatic pulse_err();
    @(negedge clk);
    while (!tx_req_ready) @(negedge clk);
    link_err = 1'b1;
    @(negedge clk);
    link_err = 1'b0;
  endtask

  task automatic run_all();
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_req_ready && !tx_hdr_valid && !tx_byte_valid && !rx_addr_valid, "R10 reset state",
        {tx_req_ready, tx_hdr_valid, tx_byte_valid, rx_addr_valid}, 32'h8);
    started = 1;
    send(2'd0, 32'h1234_5678, 1'b0); mask_is(4'hF, "R5 first after reset");
    send(2'd0, 32'h1234_5678, 1'b0); mask_is(4'h0, "R1 same address");
    send(2'd1, 32'h1234_5699, 1'b0); mask_is(4'h1, "R1 byte0 change");
    send(2'd0, 32'hAB34_5699, 1'b0); mask_is(4'h8, "R1 byte3 change");
    send(2'd2, 32'hFFFF_FFFF, 1'b0); mask_is(4'h0, "R3 response no mask");
    send(2'd0, 32'hAB34_0099, 1'b0); mask_is(4'h2, "R3 history kept over response");
    send(2'd0, 32'hAB34_0099, 1'b1); mask_is(4'hF, "R4 disable forces full");
    pulse_err();
    send(2'd1, 32'hAB34_0099, 1'b0); mask_is(4'hF, "R5 full after error");
    send(2'd0, 32'h5534_AA99, 1'b0); mask_is(4'hA, "R1 bytes 1 and 3");
    a = 32'hAB34_AA99;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0) pulse_err();
      for (int n = 0; n < 4; n++)
        if ($urandom_range(0, 2) == 0) a[8*n +: 8] = 8'($urandom);
      send((r < 3) ? 2'd2 : 2'($urandom_range(0, 1)), a, r == 4);
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule